// File: doc/BRIEF.md
# Dual-Clock FIFO Reset Sequencer

This controller sits beside a FIFO whose write and read sides run on unrelated clocks. It takes one active-low asynchronous reset request and gives each side its own reset. That reset goes low at once, with no clock edge needed. It comes back high only after the released request has crossed a synchronizer clocked by that side's clock and a minimum hold count has elapsed. After release, a per-side ready output stays low for a settling count. The FIFO side may be used only once that count has run out.

While a side is not ready, the controller masks that side's enable from the user. It also reports the FIFO as full to the writer, so upstream logic cannot write while reset is held or while it is settling. A write can therefore never land on the edge where the write reset is released. A new request at any point, including mid-sequence, clears both sides at once and starts the whole sequence again.

Top module: `fifo_rst_seq`

## Requirements
- R1: While `rst_req_n` is low, both FIFO resets and both ready outputs are low and `full_out` is high. This takes effect immediately, without waiting for any clock edge.
- R2: After `rst_req_n` rises, each side's FIFO reset rises on the rising edge number SYNC_STAGES + max(HOLD_CYCLES, 3, SYNC_STAGES) of that side's own clock (edge 10 with defaults 2 and 8), counting from the first edge after release. It stays low on every earlier edge.
- R3: Each side's ready output rises SETTLE_CYCLES edges of its own clock after its FIFO reset rises (edge 70 with defaults), and is low before that.
- R4: A request pulse shorter than one clock period still produces the full hold and settling sequence of R2 and R3 on both sides.
- R5: A request arriving while a side is still settling drops its reset and ready at once, and the edge counts of R2 and R3 start again from the new release.
- R6: `wr_en_out` equals `wr_en_in` AND `wr_ready`, so it is low on the write edge at which the write reset is released.
- R7: `rd_en_out` equals `rd_en_in` AND `rd_ready`.
- R8: `full_out` equals `full_in` OR NOT `wr_ready`, so it is forced high during reset and settling.
- R9: The two sides sequence independently: with a slower read clock, `wr_ready` rises while `rd_ready` is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_req_n | input | 1 | Asynchronous reset request, active low |
| wr_en_in | input | 1 | Write enable from the user |
| rd_en_in | input | 1 | Read enable from the user |
| full_in | input | 1 | Full flag from the FIFO |
| wr_en_out | output | 1 | Gated write enable to the FIFO |
| rd_en_out | output | 1 | Gated read enable to the FIFO |
| full_out | output | 1 | Full flag toward the user, forced high when not ready |
| fifo_wr_rst_n | output | 1 | Write-side FIFO reset, active low |
| fifo_rd_rst_n | output | 1 | Read-side FIFO reset, active low |
| wr_ready | output | 1 | Write side usable |
| rd_ready | output | 1 | Read side usable |

## Verification
The bench counts edges of each clock from the release of the request and checks the exact edge of reset release and of ready. A design with one synchronizer stage too few or too many, or an off-by-one hold or settle count, shows up there as a one-edge shift. Sub-cycle request pulses are applied to catch a design that only samples the request on a clock edge, or that lets a short pulse shorten the hold. A request is also re-issued during settling to catch a counter that resumes instead of restarting. The enable held high across release catches a design that lets a write slip through on the release edge or that lifts the full mask early.

// File: rtl/fifo_rst_pkg.sv
`timescale 1ns/1ps
package fifo_rst_pkg;

  // Encoding chosen so every legal transition flips a single bit:
  // bit 0 is the released reset, bit 1 is ready.
  typedef enum logic [1:0] {
    SEQ_HOLD   = 2'b00,
    SEQ_SETTLE = 2'b01,
    SEQ_RUN    = 2'b11
  } seq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rst_sync_chain.sv
`timescale 1ns/1ps
module rst_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rel_o = sh_q[STAGES-1];

  AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rel_o) |-> $past(sh_q[STAGES-2])); // R2

endmodule

// File: rtl/rst_dom_seq.sv
`timescale 1ns/1ps
module rst_dom_seq
  import fifo_rst_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int HOLD_CYCLES   = 8,
  parameter int SETTLE_CYCLES = 60
) (
  input  logic clk,
  input  logic arst_n,
  output logic dom_rst_n,
  output logic ready
);

  localparam int SYNC_EFF   = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;
  localparam int HOLD_EFF   = max3(HOLD_CYCLES, 3, SYNC_EFF);
  localparam int SETTLE_EFF = (SETTLE_CYCLES < 1) ? 1 : SETTLE_CYCLES;
  localparam int CNT_MAX    = (HOLD_EFF > SETTLE_EFF) ? HOLD_EFF : SETTLE_EFF;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  logic             sync_rel;
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  rst_sync_chain #(.STAGES(SYNC_EFF)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rel_o  (sync_rel)
  );

  assign cnt_en = (state_q == SEQ_SETTLE) || ((state_q == SEQ_HOLD) && sync_rel);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_HOLD: begin
        if (sync_rel) begin
          if (cnt_q == CNT_W'(HOLD_EFF - 1)) begin
            state_d = SEQ_SETTLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SEQ_SETTLE: begin
        if (cnt_q == CNT_W'(SETTLE_EFF - 1)) begin
          state_d = SEQ_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = SEQ_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= SEQ_HOLD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign dom_rst_n = state_q[0];
  assign ready     = state_q[1];

  AST_RELEASE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(dom_rst_n) |-> $past(sync_rel)); // R2
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q < CNT_W'(CNT_MAX)); // R2
  AST_READY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(ready) |-> $past(dom_rst_n)); // R3

endmodule

// File: rtl/fifo_rst_seq.sv
`timescale 1ns/1ps
module fifo_rst_seq #(
  parameter int SYNC_STAGES   = 2,
  parameter int HOLD_CYCLES   = 8,
  parameter int SETTLE_CYCLES = 60
) (
  input  logic wr_clk,
  input  logic rd_clk,
  input  logic rst_req_n,
  input  logic wr_en_in,
  input  logic rd_en_in,
  input  logic full_in,
  output logic wr_en_out,
  output logic rd_en_out,
  output logic full_out,
  output logic fifo_wr_rst_n,
  output logic fifo_rd_rst_n,
  output logic wr_ready,
  output logic rd_ready
);

  localparam int NDOM = 2;  // index 0: write side, 1: read side

  logic [NDOM-1:0] dom_clk;
  logic [NDOM-1:0] dom_rst_n;
  logic [NDOM-1:0] dom_rdy;

  assign dom_clk = {rd_clk, wr_clk};

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    rst_dom_seq #(
      .SYNC_STAGES   (SYNC_STAGES),
      .HOLD_CYCLES   (HOLD_CYCLES),
      .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_seq (
      .clk       (dom_clk[g]),
      .arst_n    (rst_req_n),
      .dom_rst_n (dom_rst_n[g]),
      .ready     (dom_rdy[g])
    );
  end

  assign fifo_wr_rst_n = dom_rst_n[0];
  assign fifo_rd_rst_n = dom_rst_n[1];
  assign wr_ready      = dom_rdy[0];
  assign rd_ready      = dom_rdy[1];

  assign wr_en_out = wr_en_in & wr_ready;
  assign rd_en_out = rd_en_in & rd_ready;
  assign full_out  = full_in | ~wr_ready;

  AST_NO_WR_AT_RELEASE: assert property (@(posedge wr_clk) disable iff (!rst_req_n)
    $rose(fifo_wr_rst_n) |-> !wr_en_out); // R6
  AST_FULL_IN_RESET: assert property (@(posedge wr_clk) disable iff (!rst_req_n)
    !fifo_wr_rst_n |-> full_out); // R8
  AST_NO_RD_IN_RESET: assert property (@(posedge rd_clk) disable iff (!rst_req_n)
    !fifo_rd_rst_n |-> !rd_en_out); // R7

endmodule

// File: tb/fifo_rst_seq_tb.sv
`timescale 1ns/1ps
module fifo_rst_seq_tb;

  localparam int SYNC   = 2;
  localparam int HOLD   = 8;
  localparam int SETTLE = 60;
  localparam int HOLD_E = (HOLD > 3) ? ((HOLD > SYNC) ? HOLD : SYNC) : ((SYNC > 3) ? SYNC : 3);
  localparam int T_REL  = SYNC + HOLD_E;
  localparam int T_RDY  = T_REL + SETTLE;
  localparam int NVEC   = 8;

  // {wr_en_in, rd_en_in, full_in, exp wr_en_out, exp rd_en_out, exp full_out} while ready
  localparam logic [5:0] VEC [NVEC] = '{
    6'b000_000, 6'b100_100, 6'b010_010, 6'b001_001,
    6'b110_110, 6'b101_101, 6'b011_011, 6'b111_111
  };

  logic wr_clk, rd_clk, rst_req_n;
  logic wr_en_in, rd_en_in, full_in;
  logic wr_en_out, rd_en_out, full_out;
  logic fifo_wr_rst_n, fifo_rd_rst_n, wr_ready, rd_ready;

  int n_chk;
  int n_bad;

  fifo_rst_seq #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD), .SETTLE_CYCLES(SETTLE)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_req_n(rst_req_n),
    .wr_en_in(wr_en_in), .rd_en_in(rd_en_in), .full_in(full_in),
    .wr_en_out(wr_en_out), .rd_en_out(rd_en_out), .full_out(full_out),
    .fifo_wr_rst_n(fifo_wr_rst_n), .fifo_rd_rst_n(fifo_rd_rst_n),
    .wr_ready(wr_ready), .rd_ready(rd_ready)
  );

  initial wr_clk = 1'b0;
  always #2 wr_clk = ~wr_clk;   // 250 MHz
  initial rd_clk = 1'b0;
  always #3 rd_clk = ~rd_clk;

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic chk_all_reset(input string rq);
    chk(rq, "fifo_wr_rst_n", fifo_wr_rst_n, 1'b0);
    chk(rq, "fifo_rd_rst_n", fifo_rd_rst_n, 1'b0);
    chk(rq, "wr_ready", wr_ready, 1'b0);
    chk(rq, "rd_ready", rd_ready, 1'b0);
    chk(rq, "full_out", full_out, 1'b1);
  endtask

  // wr_en_in = rd_en_in = 1, full_in = 0 held throughout tracking
  task automatic track_wr(input string rq);
    for (int e = 1; e <= T_RDY + 2; e++) begin
      @(posedge wr_clk); #1;
      chk(rq, "wr rst release edge", fifo_wr_rst_n, e >= T_REL);
      chk(rq, "wr ready edge", wr_ready, e >= T_RDY);
      chk("R6", "wr_en_out gated", wr_en_out, e >= T_RDY);
      chk("R8", "full_out forced", full_out, e < T_RDY);
      if (e == T_RDY) chk("R9", "rd_ready still low", rd_ready, 1'b0);
    end
  endtask

  task automatic track_rd(input string rq);
    for (int e = 1; e <= T_RDY + 2; e++) begin
      @(posedge rd_clk); #1;
      chk(rq, "rd rst release edge", fifo_rd_rst_n, e >= T_REL);
      chk(rq, "rd ready edge", rd_ready, e >= T_RDY);
      chk("R7", "rd_en_out gated", rd_en_out, e >= T_RDY);
    end
  endtask

  task automatic short_pulse();
    @(negedge wr_clk);
    rst_req_n = 1'b0;
    #0.2;
    chk_all_reset("R1");
    #0.3;
    rst_req_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_req_n = 1'b0;
    wr_en_in = 1'b0; rd_en_in = 1'b0; full_in = 1'b0;
    #1;
    chk_all_reset("R1");
    repeat (5) @(posedge wr_clk);

    // table under reset: enables masked, full forced (R6 R7 R8)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge wr_clk);
      {wr_en_in, rd_en_in, full_in} = VEC[i][5:3];
      #0.5;
      chk("R6", "wr_en_out in reset", wr_en_out, 1'b0);
      chk("R7", "rd_en_out in reset", rd_en_out, 1'b0);
      chk("R8", "full_out in reset", full_out, 1'b1);
    end

    // release and track both domains (R2 R3 R9)
    @(negedge wr_clk);
    wr_en_in = 1'b1; rd_en_in = 1'b1; full_in = 1'b0;
    rst_req_n = 1'b1;
    fork
      track_wr("R2");
      track_rd("R3");
    join

    // table walk with both sides ready (R6 R7 R8)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge wr_clk);
      {wr_en_in, rd_en_in, full_in} = VEC[i][5:3];
      #0.5;
      chk("R6", "wr_en_out pass", wr_en_out, VEC[i][2]);
      chk("R7", "rd_en_out pass", rd_en_out, VEC[i][1]);
      chk("R8", "full_out pass", full_out, VEC[i][0]);
    end

    // sub-cycle request pulse from the ready state (R4)
    wr_en_in = 1'b1; rd_en_in = 1'b1; full_in = 1'b0;
    short_pulse();
    fork
      track_wr("R4");
      track_rd("R4");
    join

    // request during settling restarts the sequence (R5)
    short_pulse();
    repeat (40) @(posedge wr_clk);
    #1;
    chk("R5", "wr settling before restart", fifo_wr_rst_n, 1'b1);
    short_pulse();
    fork
      track_wr("R5");
      track_rd("R5");
    join

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule